// File: doc/BRIEF.md
# Reconfigurable Lookup-Table RAM Cell

This block holds two 16-bit lookup tables, called F and G. A static configuration input turns the pair into one of three read/write memories:
- two 16x1 memories that share one address (16x2);
- a single 32x1 memory;
- a 16x1 memory with one write/read port and a second, independent read port.

Writes take effect on the rising clock edge. Reads are combinational from the addressed entries. Both tables are loaded from parameters at reset.

Four control pins serve the memory:
- a clock enable;
- a write enable;
- two data bits. The second data bit changes meaning with the configuration: it is G's write data in the 16x2 shape and the fifth address bit in the 32x1 shape.

The block sits next to logic that needs small, fast scratch storage. The surrounding logic holds `cfg_org` steady while it uses the memory. The block has no streaming data path, so every pin is a plain level-sampled signal and there is no valid/ready handshake or back-pressure.

Top module: `lutram_cell`

## Requirements
- R1: While `rst_n` is low, table F holds `INIT_F` and table G holds `INIT_G`. Bit k of each parameter is entry k of its table.
- R2: A table changes only on a rising edge of `clk` where `clk_en` and `wr_en` are both 1. With either of them at 0, no entry changes.
- R3: Reads are combinational. In a cycle that writes the entry being read, the outputs show the old value until the rising edge.
- R4: With `cfg_org` = 2'b00 (16x2), a write stores `din0` into F[`addr`] and `din1` into G[`addr`]. `q_f` = F[`addr`] and `q_g` = G[`addr`].
- R5: With `cfg_org` = 2'b01 (32x1), `din1` is address bit 4:
  - when `din1` = 0, a write stores `din0` into F[`addr`], and `q_f` = F[`addr`];
  - when `din1` = 1, a write stores `din0` into G[`addr`], and `q_f` = G[`addr`];
  - `q_g` = G[`addr`] in either case.
- R6: With `cfg_org` = 2'b10 (dual port), a write stores `din0` into both F[`addr`] and G[`addr`]. `din1` is ignored. `q_f` = F[`addr`] and `q_g` = G[`addr_b`].
- R7: With `cfg_org` = 2'b11 (reserved), no entry is written. Reads behave as in R4.
- R8: In dual-port mode, a write at `addr` and a read at a different `addr_b` proceed in the same cycle. A later read of the written entry through `addr_b` returns the new data in the cycle right after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; reloads both tables |
| cfg_org | input | 2 | Organisation: 00 16x2, 01 32x1, 10 dual port, 11 reserved |
| clk_en | input | 1 | Clock enable for writes |
| wr_en | input | 1 | Write enable |
| din0 | input | 1 | Write data for F, and for G outside 16x2 |
| din1 | input | 1 | G write data (16x2) or address bit 4 (32x1) |
| addr | input | 4 | Write address and first read address |
| addr_b | input | 4 | Second read address (dual port only) |
| q_f | output | 1 | First read port (F, or the selected table in 32x1) |
| q_g | output | 1 | Second read port (G) |

## Verification
The read outputs are due in the same cycle their address and `din1` settle, because no register sits on the read path. A write is due one rising edge after it is presented, and reset applies at once.

The bench drives every input on the falling edge and samples both outputs one nanosecond later. That sample shows the contents from before the coming edge, which checks R3. The bench's array model updates only at the rising edge, so the next cycle's sample is the first to expect the new data.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
  typedef enum logic [1:0] {
    ORG_16X2 = 2'b00,
    ORG_32X1 = 2'b01,
    ORG_DUAL = 2'b10,
    ORG_OFF  = 2'b11
  } org_e;

  localparam int unsigned NUM_TABLES = 2;
  localparam int unsigned TBL_F = 0;
  localparam int unsigned TBL_G = 1;
endpackage

// File: rtl/lutram_table.sv
module lutram_table #(
  parameter int unsigned DEPTH = 16,
  parameter logic [DEPTH-1:0] INIT = '0,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bits_q <= INIT;
    else if (we) bits_q[waddr] <= wdata;
  end

  assign rdata = bits_q[raddr];

  // Assertion support: remember the last write so it can be checked one edge later.
  logic          chk_we;
  logic [AW-1:0] chk_wa;
  logic          chk_wd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_we <= 1'b0;
      chk_wa <= '0;
      chk_wd <= 1'b0;
    end else begin
      chk_we <= we;
      chk_wa <= waddr;
      chk_wd <= wdata;
    end
  end

  // R2: an accepted write is present in the table after the edge.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_we |-> (bits_q[chk_wa] == chk_wd));

  // R2: without a write strobe the contents hold.
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bits_q));
endmodule

// File: rtl/lutram_wr_ctrl.sv
module lutram_wr_ctrl
  import lutram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  org_e org,
  input  logic clk_en,
  input  logic wr_en,
  input  logic din0,
  input  logic din1,
  output logic we_f,
  output logic we_g,
  output logic wd_f,
  output logic wd_g
);
  logic strobe;
  assign strobe = clk_en & wr_en;

  always_comb begin
    we_f = 1'b0;
    we_g = 1'b0;
    wd_f = din0;
    wd_g = din0;
    unique case (org)
      ORG_16X2: begin
        we_f = strobe;
        we_g = strobe;
        wd_g = din1;
      end
      ORG_32X1: begin
        we_f = strobe & ~din1;
        we_g = strobe &  din1;
      end
      ORG_DUAL: begin
        we_f = strobe;
        we_g = strobe;
      end
      default: begin
        we_f = 1'b0;
        we_g = 1'b0;
      end
    endcase
  end

  // R2: no table strobe unless both enables are high.
  p_gated_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && wr_en) |-> !(we_f || we_g));

  // R5: the fifth address bit picks exactly one table.
  p_one_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (org == ORG_32X1) |-> $onehot0({we_f, we_g}));

  // R7: the reserved organisation never writes.
  p_reserved_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (org == ORG_OFF) |-> !(we_f || we_g));
endmodule

// File: rtl/lutram_rd_sel.sv
module lutram_rd_sel
  import lutram_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  org_e          org,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] addr_b,
  input  logic          din1,
  input  logic          f_rd,
  input  logic          g_rd,
  output logic [AW-1:0] g_raddr,
  output logic          q_f,
  output logic          q_g
);
  always_comb begin
    g_raddr = (org == ORG_DUAL) ? addr_b : addr;
    q_g     = g_rd;
    q_f     = ((org == ORG_32X1) && din1) ? g_rd : f_rd;
  end
endmodule

// File: rtl/lutram_cell.sv
module lutram_cell
  import lutram_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter logic [DEPTH-1:0] INIT_F = 16'hA5C3,
  parameter logic [DEPTH-1:0] INIT_G = 16'h0F69,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_org,
  input  logic          clk_en,
  input  logic          wr_en,
  input  logic          din0,
  input  logic          din1,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] addr_b,
  output logic          q_f,
  output logic          q_g
);
  org_e org;
  assign org = org_e'(cfg_org);

  logic          we_v [NUM_TABLES];
  logic          wd_v [NUM_TABLES];
  logic [AW-1:0] ra_v [NUM_TABLES];
  logic          rd_v [NUM_TABLES];
  logic [AW-1:0] g_raddr;

  lutram_wr_ctrl u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .org    (org),
    .clk_en (clk_en),
    .wr_en  (wr_en),
    .din0   (din0),
    .din1   (din1),
    .we_f   (we_v[TBL_F]),
    .we_g   (we_v[TBL_G]),
    .wd_f   (wd_v[TBL_F]),
    .wd_g   (wd_v[TBL_G])
  );

  assign ra_v[TBL_F] = addr;
  assign ra_v[TBL_G] = g_raddr;

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    localparam logic [DEPTH-1:0] TINIT = (t == TBL_F) ? INIT_F : INIT_G;
    lutram_table #(.DEPTH(DEPTH), .INIT(TINIT)) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_v[t]),
      .waddr (addr),
      .wdata (wd_v[t]),
      .raddr (ra_v[t]),
      .rdata (rd_v[t])
    );
  end

  lutram_rd_sel #(.AW(AW)) u_rd (
    .org     (org),
    .addr    (addr),
    .addr_b  (addr_b),
    .din1    (din1),
    .f_rd    (rd_v[TBL_F]),
    .g_rd    (rd_v[TBL_G]),
    .g_raddr (g_raddr),
    .q_f     (q_f),
    .q_g     (q_g)
  );

  // R6: in dual-port mode both tables receive the same write.
  p_dual_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (org == ORG_DUAL) |-> (we_v[TBL_F] == we_v[TBL_G]) && (wd_v[TBL_F] == wd_v[TBL_G]));

  // R8: a dual-port write leaves G readable at the written address through port B.
  p_dual_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((org == ORG_DUAL) && clk_en && wr_en) |=>
      ((org != ORG_DUAL) || (addr_b != $past(addr)) || (q_g == $past(din0))));
endmodule

// File: tb/lutram_cell_bench.sv
module lutram_cell_bench;
  localparam logic [15:0] IF = 16'hA5C3;
  localparam logic [15:0] IG = 16'h0F69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_org = 2'b00;
  logic clk_en = 1'b0, wr_en = 1'b0, din0 = 1'b0, din1 = 1'b0;
  logic [3:0] addr = '0, addr_b = '0;
  logic q_f, q_g;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mf, mg;

  always #4 clk = ~clk;

  lutram_cell #(.DEPTH(16), .INIT_F(IF), .INIT_G(IG)) u_lutram_cell (
    .clk(clk), .rst_n(rst_n), .cfg_org(cfg_org), .clk_en(clk_en), .wr_en(wr_en),
    .din0(din0), .din1(din1), .addr(addr), .addr_b(addr_b), .q_f(q_f), .q_g(q_g)
  );

  // {org, ce, we, d0, d1, addr, addr_b}
  localparam int NV = 16;
  localparam logic [13:0] VECS [0:NV-1] = '{
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 4'd0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd0},
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 4'd0},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 4'd0},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 4'd0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd0},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5, 4'd0},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5, 4'd0},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 4'd0},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5, 4'd0},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7, 4'd7},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9, 4'd7},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7, 4'd7},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd7},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3, 4'd3},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd3}
  };

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic step(logic [1:0] o, logic ce, logic we, logic d0, logic d1,
                      logic [3:0] a, logic [3:0] a2, string force_tag);
    logic ef, eg;
    string tag;
    @(negedge clk);
    cfg_org = o; clk_en = ce; wr_en = we; din0 = d0; din1 = d1; addr = a; addr_b = a2;
    #1;
    case (o)
      2'd1:    begin ef = d1 ? mg[a] : mf[a]; eg = mg[a];  tag = "R5"; end
      2'd2:    begin ef = mf[a];              eg = mg[a2]; tag = "R6"; end
      2'd3:    begin ef = mf[a];              eg = mg[a];  tag = "R7"; end
      default: begin ef = mf[a];              eg = mg[a];  tag = "R4"; end
    endcase
    if (o != 2'd3 && (ce ^ we)) tag = "R2";
    if (o != 2'd3 && ce && we) tag = (o == 2'd2 && a != a2) ? "R8" : "R3";
    if (force_tag != "") tag = force_tag;
    chk(tag, "q_f", q_f, ef);
    chk(tag, "q_g", q_g, eg);
    @(posedge clk);
    if (ce && we) begin
      case (o)
        2'd0: begin mf[a] = d0; mg[a] = d1; end
        2'd1: if (d1) mg[a] = d0; else mf[a] = d0;
        2'd2: begin mf[a] = d0; mg[a] = d0; end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL all-R watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    mf = IF; mg = IG;
    repeat (3) @(posedge clk);
    // R1: contents readable during reset equal the parameters
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); addr = 4'(k); #1;
      chk("R1", "q_f reset", q_f, IF[k]);
      chk("R1", "q_g reset", q_g, IG[k]);
    end
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VECS[i];
      step(v[13:12], v[11], v[10], v[9], v[8], v[7:4], v[3:0], "");
    end

    // R8: port B reads the freshly written entry the cycle after the edge
    step(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'd12, 4'd1, "R8");
    step(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd12, "R8");

    // R5: full 32-entry sweep, write then read back
    for (int k = 0; k < 32; k++)
      step(2'd1, 1'b1, 1'b1, 1'(k % 3 == 0), 1'(k >> 4), 4'(k), 4'd0, "R5");
    for (int k = 0; k < 32; k++)
      step(2'd1, 1'b0, 1'b0, 1'b0, 1'(k >> 4), 4'(k), 4'd0, "R5");

    // Random sequences in every organisation
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      step(r[1:0], r[2] | r[3], r[4] | r[5], r[6], r[7], r[11:8], r[15:12], "");
    end

    // R1: reset in the middle of operation restores the initial tables
    @(negedge clk); rst_n = 1'b0;
    mf = IF; mg = IG;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 16; k++)
      step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'(k), 4'd0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule